// File: doc/BRIEF.md
# Nine-Level Multicarrier PWM Gate Modulator

This block drives the eight power switches of a single-phase, nine-level inverter. The inverter is built from three asymmetric DC sources in a 1:2:1 ratio. A phase accumulator and a quarter-wave sine table produce a 50 Hz reference. A modulation-index word scales the reference. Eight triangle carriers run at 1200 Hz. They are stacked in non-overlapping bands and move in phase, because they all come from one shared up/down counter.

The reference is compared with each carrier. The comparator results are summed into one level code between -4 and +4. A fixed lookup turns that code into four main gates and four complementary gates.

Each gate is switched so that no two bridge states overlap:
- A gate that leaves the pattern drops at once.
- A gate that joins the pattern waits a fixed number of dead-time cycles before it asserts.

Reset, or a low enable, parks the bridge in the zero state with every complementary gate on.

Top module: `mlpwm_modulator`

## Requirements
- R1: During reset, and in the first cycle after a reset is sampled, `level_code` is 0, `s_gate` is 4'b0000 and `g_gate` is 4'b1111.
- R2: `level_code` is a 4-bit two's-complement number equal to the count of carriers the reference exceeds, minus 4, so it always lies in -4..+4.
- R3: With `mod_index` = 0 and enable high, `level_code` stays 0 for a whole reference period.
- R4: With `mod_index` = 255, each of the nine levels, from -4 up to +4, appears within one reference period.
- R5: With `mod_index` = 128, `level_code` stays within -2..+2 and reaches both -2 and +2 within one reference period.
- R6: Bit i of `s_gate` is main switch i+1 and bit i of `g_gate` is complementary switch i+1. The wanted patterns as {g_gate, s_gate} are:
  - +4: 1010_0101
  - +3: 0010_0111
  - +2: 0011_1100
  - +1: 1110_0001
  - 0: 1111_0000
  - -1: 0001_1110
  - -2: 1100_0011
  - -3: 1101_0010
  - -4: 0101_1010
- R7: Once `level_code` has been unchanged for DEAD_CYC cycles, exactly four gates are on, and they are the R6 pattern.
- R8: A gate whose bit becomes wanted stays off for exactly DEAD_CYC cycles of continuous want and then turns on.
- R9: A gate no longer wanted by the current `level_code` is off in the same cycle the code changes.
- R10: One cycle after enable is sampled low, `level_code` is 0. After DEAD_CYC further cycles the gates show the level-0 pattern.
- R11: The reference period is CLK_HZ/REF_HZ cycles. The spacing between successive peaks of the level waveform matches it within one carrier period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | High runs modulation; low forces level 0 |
| mod_index | input | MI_W (8) | Reference amplitude scale, full scale at 2^MI_W |
| s_gate | output | 4 | Main switch gates, bit i = switch i+1 |
| g_gate | output | 4 | Complementary switch gates, bit i = switch i+1 |
| level_code | output | 4 | Signed output level, -4..+4 |

## Verification
The gates follow `level_code` combinationally, so the bench compares gates against the level seen in the same cycle. It counts how many samples each gate has been wanted without a break, and expects a gate on only once that count reaches DEAD_CYC.

`level_code` is registered after the enable and comparator stage. Hence the enable and reset checks sample one clock after the input is taken, and the full level-0 pattern is checked DEAD_CYC cycles later.

Waveform-shape checks depend on the phase accumulator and the carrier. They are therefore judged over a whole reference period, after a settling gap. The period check allows one carrier period of jitter.

// File: rtl/mlpwm_pkg.sv
`timescale 1ns/1ps
// Shared types and the level-to-gate lookup for the nine-level modulator.
// Assumes the asymmetric 1:2:1 source bridge; the pattern table is fixed.
package mlpwm_pkg;

    localparam int NUM_CARRIERS = 8;
    localparam int NUM_GATES    = 8;

    typedef logic signed [3:0] level_t;

    typedef struct packed {
        logic [3:0] g;   // complementary gates, bit i = switch i+1
        logic [3:0] s;   // main gates, bit i = switch i+1
    } gate_pat_t;

    // Returns the four-gate on-set for a level; zero uses all complementary gates.
    function automatic gate_pat_t level_pattern(level_t lv);
        gate_pat_t p;
        case (4'(lv))
            4'h4:    p = '{g: 4'b1010, s: 4'b0101};
            4'h3:    p = '{g: 4'b0010, s: 4'b0111};
            4'h2:    p = '{g: 4'b0011, s: 4'b1100};
            4'h1:    p = '{g: 4'b1110, s: 4'b0001};
            4'hF:    p = '{g: 4'b0001, s: 4'b1110};
            4'hE:    p = '{g: 4'b1100, s: 4'b0011};
            4'hD:    p = '{g: 4'b1101, s: 4'b0010};
            4'hC:    p = '{g: 4'b0101, s: 4'b1010};
            default: p = '{g: 4'b1111, s: 4'b0000};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/mlpwm_refgen.sv
`timescale 1ns/1ps
// Sinusoidal reference generator: phase accumulator, quarter-wave sine
// table built at elaboration, amplitude scaling by the modulation index.
// Output is offset binary centred on 2^(REF_W-1). Two-cycle latency.
// Assumes CLK_HZ much larger than REF_HZ so the phase step is nonzero.
module mlpwm_refgen #(
    parameter int CLK_HZ = 200_000_000,
    parameter int REF_HZ = 50,
    parameter int PH_W   = 32,
    parameter int LUT_AW = 6,
    parameter int REF_W  = 7,
    parameter int MI_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MI_W-1:0]  mod_index,
    output logic [REF_W-1:0] ref_o
);
    localparam int AMP_W = REF_W - 1;
    localparam int LUT_N = 1 << LUT_AW;
    localparam int AMP   = (1 << AMP_W) - 1;
    localparam int MID   = 1 << AMP_W;
    localparam real HALF_PI = 1.5707963267948966;
    localparam logic [PH_W-1:0] PH_INC =
        PH_W'(longint'(real'(REF_HZ) * (2.0 ** PH_W) / real'(CLK_HZ)));

    logic [AMP_W-1:0] lut_w [LUT_N];

    // One table entry per address, sampled at the middle of each step.
    for (genvar i = 0; i < LUT_N; i++) begin : g_lut
        localparam int VAL = int'(real'(AMP) *
            $sin(HALF_PI * (real'(i) + 0.5) / real'(LUT_N)));
        assign lut_w[i] = AMP_W'(VAL);
    end

    logic [PH_W-1:0]       phase_q;
    logic [1:0]            quad;
    logic [LUT_AW-1:0]     addr, addr_eff;
    logic [AMP_W-1:0]      mag_q;
    logic                  neg_q;
    logic [AMP_W+MI_W-1:0] prod;
    logic [AMP_W-1:0]      scaled;
    logic                  unused_bits;

    assign quad     = phase_q[PH_W-1 -: 2];
    assign addr     = phase_q[PH_W-3 -: LUT_AW];
    assign addr_eff = quad[0] ? ~addr : addr;
    assign unused_bits = ^{phase_q[PH_W-3-LUT_AW:0], prod[MI_W-1:0]};

    // Advance the phase by one step per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + PH_INC;
    end

    // Look up the magnitude and remember the half-wave sign.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag_q <= '0;
            neg_q <= 1'b0;
        end else begin
            mag_q <= lut_w[addr_eff];
            neg_q <= quad[1];
        end
    end

    assign prod   = {{MI_W{1'b0}}, mag_q} * {{AMP_W{1'b0}}, mod_index};
    assign scaled = prod[AMP_W+MI_W-1:MI_W];

    // Apply the sign around mid-scale and register the reference.
    always_ff @(posedge clk) begin
        if (!rst_n)     ref_o <= REF_W'(MID);
        else if (neg_q) ref_o <= REF_W'(MID) - {1'b0, scaled};
        else            ref_o <= REF_W'(MID) + {1'b0, scaled};
    end

endmodule

// File: rtl/mlpwm_carrier.sv
`timescale 1ns/1ps
// Shared triangle carrier: an up/down counter over 0..2^CAR_W-1 stepped
// by a prescaler so one full up-and-down sweep lasts about 1/CAR_HZ.
// All stacked carriers are offsets of this one value, hence in phase.
module mlpwm_carrier #(
    parameter int CLK_HZ = 200_000_000,
    parameter int CAR_HZ = 1200,
    parameter int CAR_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CAR_W-1:0] tri_o
);
    localparam int TOP     = (1 << CAR_W) - 1;
    localparam int STEPS   = 2 * TOP;
    localparam int PRE_RAW = CLK_HZ / (CAR_HZ * STEPS);
    localparam int PRE     = (PRE_RAW < 1) ? 1 : PRE_RAW;
    localparam int PRE_W   = $clog2(PRE + 1);

    logic [PRE_W-1:0] pre_q;
    logic             step;
    logic             up_q;

    assign step = (pre_q == PRE_W'(PRE - 1));

    // Divide the clock down to the carrier step rate.
    always_ff @(posedge clk) begin
        if (!rst_n)    pre_q <= '0;
        else if (step) pre_q <= '0;
        else           pre_q <= pre_q + 1'b1;
    end

    // Sweep up to the top, then down to zero, turning at each end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tri_o <= '0;
            up_q  <= 1'b1;
        end else if (step) begin
            if (up_q) begin
                if (tri_o == CAR_W'(TOP)) begin
                    up_q  <= 1'b0;
                    tri_o <= tri_o - 1'b1;
                end else begin
                    tri_o <= tri_o + 1'b1;
                end
            end else begin
                if (tri_o == '0) begin
                    up_q  <= 1'b1;
                    tri_o <= tri_o + 1'b1;
                end else begin
                    tri_o <= tri_o - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mlpwm_level.sv
`timescale 1ns/1ps
// Comparator bank and level aggregator. Carrier k occupies the band
// [k*2^CAR_W, (k+1)*2^CAR_W - 1]; each comparator is high when the reference
// is strictly above its carrier. The count, minus four, is registered
// as the signed level; a low enable registers level 0 instead.
module mlpwm_level
    import mlpwm_pkg::*;
#(
    parameter int CAR_W = 4,
    parameter int REF_W = CAR_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [REF_W-1:0] ref_i,
    input  logic [CAR_W-1:0] tri_i,
    output level_t           level_o
);
    logic [NUM_CARRIERS-1:0] cmp;
    logic [3:0]              sum;

    for (genvar k = 0; k < NUM_CARRIERS; k++) begin : g_cmp
        localparam logic [REF_W-1:0] BASE = REF_W'(k << CAR_W);
        assign cmp[k] = ref_i > (BASE + REF_W'(tri_i));
    end

    // Count how many carriers lie below the reference.
    always_comb begin
        sum = '0;
        for (int k = 0; k < NUM_CARRIERS; k++) sum = sum + {3'b000, cmp[k]};
    end

    // Register the offset level, or zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)      level_o <= '0;
        else if (enable) level_o <= level_t'(sum - 4'd4);
        else             level_o <= '0;
    end

endmodule

// File: rtl/mlpwm_gatedrv.sv
`timescale 1ns/1ps
// Gate decoder with turn-on delay. Each gate has its own counter of
// cycles its bit has been wanted; it asserts only once that count
// reaches DEAD_CYC, and drops in the same cycle its bit is unwanted.
// Reset preloads the level-0 gates as already settled.
module mlpwm_gatedrv
    import mlpwm_pkg::*;
#(
    parameter int DEAD_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  level_t     level_i,
    output logic [3:0] s_gate,
    output logic [3:0] g_gate
);
    localparam int        DT_W = $clog2(DEAD_CYC + 2);
    localparam gate_pat_t REST = level_pattern(4'sd0);

    gate_pat_t             want;
    logic [NUM_GATES-1:0]  want_v;
    logic [NUM_GATES-1:0]  rest_v;
    logic [NUM_GATES-1:0]  gate_v;

    assign want   = level_pattern(level_i);
    assign want_v = want;
    assign rest_v = REST;

    for (genvar b = 0; b < NUM_GATES; b++) begin : g_dead
        logic [DT_W-1:0] cnt_q;

        // Count wanted cycles up to the dead-time limit; clear when unwanted.
        always_ff @(posedge clk) begin
            if (!rst_n)                        cnt_q <= rest_v[b] ? DT_W'(DEAD_CYC) : '0;
            else if (!want_v[b])               cnt_q <= '0;
            else if (cnt_q != DT_W'(DEAD_CYC)) cnt_q <= cnt_q + 1'b1;
        end

        assign gate_v[b] = want_v[b] && (cnt_q == DT_W'(DEAD_CYC));
    end

    assign s_gate = gate_v[3:0];
    assign g_gate = gate_v[7:4];

endmodule

// File: rtl/mlpwm_modulator.sv
`timescale 1ns/1ps
// Top of the nine-level multicarrier PWM gate modulator. Chains the
// reference generator and the shared carrier into the comparator and
// level stage, then decodes the level into dead-timed gate outputs.
// Assumes synchronous active-low reset held for at least three clocks.
module mlpwm_modulator
    import mlpwm_pkg::*;
#(
    parameter int CLK_HZ   = 200_000_000,
    parameter int REF_HZ   = 50,
    parameter int CAR_HZ   = 1200,
    parameter int CAR_W    = 4,
    parameter int MI_W     = 8,
    parameter int LUT_AW   = 6,
    parameter int PH_W     = 32,
    parameter int DEAD_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [MI_W-1:0]   mod_index,
    output logic [3:0]        s_gate,
    output logic [3:0]        g_gate,
    output logic signed [3:0] level_code
);
    localparam int REF_W = CAR_W + 3;

    logic [REF_W-1:0] ref_w;
    logic [CAR_W-1:0] tri_w;
    level_t           level_w;

    mlpwm_refgen #(
        .CLK_HZ(CLK_HZ), .REF_HZ(REF_HZ), .PH_W(PH_W),
        .LUT_AW(LUT_AW), .REF_W(REF_W), .MI_W(MI_W)
    ) u_ref (
        .clk(clk), .rst_n(rst_n), .mod_index(mod_index), .ref_o(ref_w)
    );

    mlpwm_carrier #(
        .CLK_HZ(CLK_HZ), .CAR_HZ(CAR_HZ), .CAR_W(CAR_W)
    ) u_car (
        .clk(clk), .rst_n(rst_n), .tri_o(tri_w)
    );

    mlpwm_level #(
        .CAR_W(CAR_W), .REF_W(REF_W)
    ) u_lvl (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .ref_i(ref_w), .tri_i(tri_w), .level_o(level_w)
    );

    mlpwm_gatedrv #(
        .DEAD_CYC(DEAD_CYC)
    ) u_gate (
        .clk(clk), .rst_n(rst_n), .level_i(level_w),
        .s_gate(s_gate), .g_gate(g_gate)
    );

    assign level_code = level_w;

endmodule

// File: rtl/mlpwm_checker.sv
`timescale 1ns/1ps
// Port-level property checker for the modulator, bound to the top.
// Keeps its own count of cycles the level has been steady.
module mlpwm_checker
    import mlpwm_pkg::*;
#(
    parameter int DEAD_CYC = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic [3:0]        s_gate,
    input logic [3:0]        g_gate,
    input logic signed [3:0] level_code
);
    localparam int HW = $clog2(DEAD_CYC + 2);

    gate_pat_t  pat;
    logic [7:0] gates;
    logic [7:0] pat_v;
    level_t     lvl_d;
    logic [HW-1:0] hold_q, hold_now;

    assign pat      = level_pattern(level_code);
    assign pat_v    = pat;
    assign gates    = {g_gate, s_gate};
    assign hold_now = (level_code != lvl_d) ? '0 : hold_q;

    // Track how long the level has been unchanged, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_d  <= '0;
            hold_q <= HW'(DEAD_CYC);
        end else begin
            lvl_d  <= level_code;
            hold_q <= (hold_now == HW'(DEAD_CYC)) ? hold_now : hold_now + 1'b1;
        end
    end

    // R2
    level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_code >= -4'sd4) && (level_code <= 4'sd4));

    // R9
    unwanted_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gates & ~pat_v) == 8'h00);

    // R7
    settled_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_now == HW'(DEAD_CYC)) |-> (gates == pat_v));

    // R6
    at_most_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gates) <= 4);

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (level_code == 4'sd0));

    if (DEAD_CYC > 0) begin : g_late
        // R8
        late_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((gates & ~$past(gates)) & ~$past(pat_v)) == 8'h00);
    end

endmodule

bind mlpwm_modulator mlpwm_checker #(.DEAD_CYC(DEAD_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .s_gate(s_gate), .g_gate(g_gate), .level_code(level_code)
);

// File: tb/mlpwm_modulator_bench.sv
`timescale 1ns/1ps
// Bench: vector table of operating points, then directed reset, idle,
// dead-time and period tests. A negedge monitor models gate timing.
module mlpwm_modulator_bench;

    localparam int CLK_HZ  = 600_000;
    localparam int DEAD    = 3;
    localparam int REF_CYC = 12000;
    localparam int CAR_CYC = 480;

    // Vector: {enable, mod_index[7:0], min level[3:0], max level[3:0]}
    localparam logic [16:0] VEC [4] = '{
        {1'b1, 8'd0,   4'h0, 4'h0},   // R3
        {1'b1, 8'd255, 4'hC, 4'h4},   // R4
        {1'b1, 8'd128, 4'hE, 4'h2},   // R5
        {1'b0, 8'd255, 4'h0, 4'h0}    // R10
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic [7:0] mod_index = 8'd0;
    logic [3:0] s_gate, g_gate;
    logic signed [3:0] level_code;

    int checks = 0;
    int fails = 0;
    int mon_err = 0;
    int mcnt [8];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mlpwm_modulator #(.CLK_HZ(CLK_HZ), .DEAD_CYC(DEAD)) u_mlpwm_modulator (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mod_index(mod_index),
        .s_gate(s_gate), .g_gate(g_gate), .level_code(level_code)
    );

    // Expected {g,s} on-set per level, from R6.
    function automatic logic [7:0] exp_pat(int lv);
        case (lv)
            4:  return 8'b1010_0101;
            3:  return 8'b0010_0111;
            2:  return 8'b0011_1100;
            1:  return 8'b1110_0001;
            -1: return 8'b0001_1110;
            -2: return 8'b1100_0011;
            -3: return 8'b1101_0010;
            -4: return 8'b0101_1010;
            default: return 8'b1111_0000;
        endcase
    endfunction

    // Gate timing model (R6, R8, R9): on only after DEAD wanted samples.
    always @(negedge clk) begin
        logic [7:0] p, e, got;
        if (!rst_n) begin
            p = exp_pat(0);
            for (int b = 0; b < 8; b++) mcnt[b] = p[b] ? DEAD : 0;
        end else begin
            p = exp_pat(int'(level_code));
            got = {g_gate, s_gate};
            for (int b = 0; b < 8; b++) e[b] = p[b] && (mcnt[b] >= DEAD);
            if (got !== e) begin
                mon_err++;
                if (mon_err < 5) $display("gate mismatch lvl %0d got %b want %b", level_code, got, e);
            end
            for (int b = 0; b < 8; b++) mcnt[b] = p[b] ? ((mcnt[b] < DEAD) ? mcnt[b] + 1 : DEAD) : 0;
        end
    end

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual 1 expected 0");
        summary();
    end

    initial begin
        int lmin, lmax, e0, t1, t2;
        logic [7:0] newb;

        // Reset state
        repeat (6) @(negedge clk);
        check(level_code == 0, "R1 level", int'(level_code), 0);
        check({g_gate, s_gate} == 8'hF0, "R1 gates", {g_gate, s_gate}, 8'hF0);
        rst_n = 1'b1;
        @(negedge clk);
        check({g_gate, s_gate} == 8'hF0, "R1 first cycle", {g_gate, s_gate}, 8'hF0);

        // Vector table
        for (int i = 0; i < 4; i++) begin
            enable = VEC[i][16];
            mod_index = VEC[i][15:8];
            repeat (300) @(negedge clk);
            lmin = int'(level_code);
            lmax = lmin;
            e0 = mon_err;
            for (int c = 0; c < REF_CYC + 100; c++) begin
                @(negedge clk);
                if (int'(level_code) < lmin) lmin = int'(level_code);
                if (int'(level_code) > lmax) lmax = int'(level_code);
            end
            check(lmin == int'($signed(VEC[i][7:4])), "R2 R3 R4 R5 R10 min level", lmin, int'($signed(VEC[i][7:4])));
            check(lmax == int'($signed(VEC[i][3:0])), "R2 R3 R4 R5 R10 max level", lmax, int'($signed(VEC[i][3:0])));
            check(mon_err == e0, "R6 R7 R8 R9 gate timing", mon_err - e0, 0);
        end

        // Dead time on the first step away from zero (R8, R9)
        enable = 1'b1;
        mod_index = 8'd255;
        while (level_code == 0) @(negedge clk);
        newb = exp_pat(int'(level_code)) & ~exp_pat(0);
        check(({g_gate, s_gate} & newb) == 0, "R8 new gate held", {g_gate, s_gate}, 0);
        check(({g_gate, s_gate} & ~exp_pat(int'(level_code))) == 0, "R9 drop same cycle",
              {g_gate, s_gate}, 0);
        repeat (DEAD - 1) @(negedge clk);
        check(({g_gate, s_gate} & newb) == 0, "R8 still held", {g_gate, s_gate}, 0);
        @(negedge clk);
        check({g_gate, s_gate} == exp_pat(int'(level_code)), "R8 on after dead time",
              {g_gate, s_gate}, exp_pat(int'(level_code)));

        // Reference period (R11)
        while (level_code != -4) @(negedge clk);
        while (level_code != 4) @(negedge clk);
        t1 = 0;
        while (level_code != -4) begin @(negedge clk); t1++; end
        t2 = t1;
        while (level_code != 4) begin @(negedge clk); t2++; end
        check((t2 > REF_CYC - CAR_CYC) && (t2 < REF_CYC + CAR_CYC), "R11 period", t2, REF_CYC);

        // Disable mid-run (R10)
        while (level_code == 0) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(level_code == 0, "R10 level", int'(level_code), 0);
        repeat (DEAD) @(negedge clk);
        check({g_gate, s_gate} == 8'hF0, "R10 gates", {g_gate, s_gate}, 8'hF0);

        // Reset mid-run (R1)
        enable = 1'b1;
        while (level_code == 0) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(level_code == 0, "R1 mid-run level", int'(level_code), 0);
        check({g_gate, s_gate} == 8'hF0, "R1 mid-run gates", {g_gate, s_gate}, 8'hF0);

        summary();
    end

endmodule